// File: doc/BRIEF.md
# Shadowed Configuration Mismatch Monitor

This block guards a small bank of configuration registers, such as pin-routing controls, against silent corruption. Each register has a hidden twin that only the legitimate write path can update. On every clock the block compares every live register with its twin. A bus write loads the register and its twin in the same cycle, so a write never looks like a fault. A difference that appears any other way is treated as a configuration mismatch. The block then raises a one-cycle reset request and sets a sticky flag in a 16-bit reset status word.

The surrounding chip uses the request to reset the device. The flag stays set through that device reset, so software can later see why the reset happened. Only a power-on/brown-out reset or a software write to the flag clears it. A test-only input flips one chosen bit of one live register without touching its twin, which models a disturbance such as an upset from electrostatic discharge.

Top module: `cfg_shadow_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register and every twin become zero and `mm_rst_req` is low after that edge. When `por_n` is also low, status bit 9 is cleared as well.
- R2: A write with `wr_en` high loads `wr_data` into register `wr_addr`. After that edge the value appears at `cfg_flat[wr_addr*8 +: 8]`, and all other registers keep their values.
- R3: A write of any value, repeated or not, never raises `mm_rst_req` and never sets status bit 9.
- R4: With `inj_en` high at an edge, bit `inj_bit` of register `inj_addr` is inverted in `cfg_flat` after that edge, and its twin is unchanged.
- R5: When live and twin values first disagree after an edge, `mm_rst_req` goes high after the next edge and stays high for exactly one cycle.
- R6: A disagreement that persists raises no further request. A new request comes only after the bank has returned to agreement and a new disagreement appears.
- R7: Status bit 9 is set at the same edge that raises `mm_rst_req`. It stays set through a `rst_n` reset that leaves `por_n` high. All other status bits read zero.
- R8: At an edge, `por_n` low clears status bit 9. `flag_wr_en` high loads `flag_wr_val` into status bit 9.
- R9: When a new mismatch is detected in the same cycle as a software write of 0 to the flag, the flag ends up set.
- R10: A write and an injection aimed at the same register in the same cycle leave the written value with the chosen bit inverted, and a mismatch is reported.
- R11: Rewriting a corrupted register brings the bank back into agreement. No further request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset for registers, twins and request logic |
| por_n | input | 1 | Synchronous active-low power-on/brown-out reset for the mismatch flag |
| wr_en | input | 1 | Legitimate register write strobe |
| wr_addr | input | 3 | Index of the register to write |
| wr_data | input | 8 | Write data |
| inj_en | input | 1 | Test-only bit-flip strobe |
| inj_addr | input | 3 | Index of the register to disturb |
| inj_bit | input | 3 | Bit position to invert |
| flag_wr_en | input | 1 | Software write strobe for the mismatch flag |
| flag_wr_val | input | 1 | Value written to the mismatch flag |
| cfg_flat | output | 64 | All live register values; register i sits at bits [8i+7:8i] |
| mm_rst_req | output | 1 | One-cycle configuration-mismatch reset request |
| status_word | output | 16 | Reset status word; bit 9 is the sticky mismatch flag |

## Verification
Two pairs of functions can land in the same cycle. In the first, a fresh mismatch detection meets a software clear of the flag. The bench injects a flip and, one cycle later, writes 0 to the flag while the request fires, and expects the flag to read 1. In the second, a legitimate write and an injection hit the same register on one edge. The bench expects the register to show the written byte with one bit inverted, followed by a request and a set flag. A scoreboard model built from the requirements predicts each cycle's registers, request and status word.

// File: rtl/cfgmon_pkg.sv
// Package: shared constants and types for the configuration mismatch monitor.
// Assumes a 16-bit reset status word with the mismatch flag at a fixed bit.
package cfgmon_pkg;
    localparam int STATUS_W     = 16;
    localparam int MISMATCH_BIT = 9;

    // Flag next-state selection, listed by decreasing priority.
    typedef enum logic [1:0] {
        FLAG_POWER  = 2'd0,
        FLAG_DETECT = 2'd1,
        FLAG_SOFT   = 2'd2,
        FLAG_KEEP   = 2'd3
    } flag_act_e;
endpackage

// File: rtl/cfgmon_bank.sv
// Module: cfgmon_bank
// Holds NUM_REGS live registers, each paired with a hidden twin. A write
// loads both in one edge. An injection inverts one live bit only. Assumes
// one write and one injection at most per cycle and in-range addresses.
module cfgmon_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int BIT_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         inj_en,
    input  logic [ADDR_W-1:0]            inj_addr,
    input  logic [BIT_W-1:0]             inj_bit,
    output logic [NUM_REGS*DATA_W-1:0]   live_flat,
    output logic [NUM_REGS*DATA_W-1:0]   shadow_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        logic              hit_wr;
        logic              hit_inj;
        logic [DATA_W-1:0] flip;
        logic [DATA_W-1:0] live_q;
        logic [DATA_W-1:0] twin_q;

        // Decode whether this slot is targeted by a write or by an injection.
        always_comb begin
            hit_wr  = wr_en  && (wr_addr  == ADDR_W'(g));
            hit_inj = inj_en && (inj_addr == ADDR_W'(g));
            flip    = hit_inj ? (DATA_W'(1) << inj_bit) : '0;
        end

        // Update the live copy and its twin; an injection lands on top of a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
                twin_q <= '0;
            end else if (hit_wr) begin
                live_q <= wr_data ^ flip;
                twin_q <= wr_data;
            end else begin
                live_q <= live_q ^ flip;
            end
        end

        assign live_flat[g*DATA_W +: DATA_W]   = live_q;
        assign shadow_flat[g*DATA_W +: DATA_W] = twin_q;
    end
endmodule

// File: rtl/cfgmon_compare.sv
// Module: cfgmon_compare
// Purely combinational. Reports whether any live register differs from its
// twin. Assumes both buses use the same slot packing.
module cfgmon_compare #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8
) (
    input  logic [NUM_REGS*DATA_W-1:0] live_flat,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    output logic                       mismatch
);
    logic [NUM_REGS-1:0] slot_diff;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        // Inequality of one slot.
        assign slot_diff[g] = live_flat[g*DATA_W +: DATA_W] != shadow_flat[g*DATA_W +: DATA_W];
    end

    // Any slot disagreeing is a mismatch.
    assign mismatch = |slot_diff;
endmodule

// File: rtl/cfgmon_flag.sv
// Module: cfgmon_flag
// Turns the rising edge of the mismatch level into a one-cycle reset request
// and keeps the sticky flag. Detection overrides a software write. The flag
// sits in the power-on domain (por_n) so it survives the device reset.
module cfgmon_flag
    import cfgmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic                mismatch,
    input  logic                flag_wr_en,
    input  logic                flag_wr_val,
    output logic                req,
    output logic [STATUS_W-1:0] status_word
);
    logic      seen_q;
    logic      flag_q;
    logic      detect;
    flag_act_e act;

    // New detection: a mismatch now that was absent in the previous cycle.
    assign detect = rst_n && mismatch && !seen_q;

    // Remember the last mismatch level and emit the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            req    <= 1'b0;
        end else begin
            seen_q <= mismatch;
            req    <= detect;
        end
    end

    // Pick the flag action by priority.
    always_comb begin
        if (!por_n)          act = FLAG_POWER;
        else if (detect)     act = FLAG_DETECT;
        else if (flag_wr_en) act = FLAG_SOFT;
        else                 act = FLAG_KEEP;
    end

    // Sticky flag register.
    always_ff @(posedge clk) begin
        unique case (act)
            FLAG_POWER:  flag_q <= 1'b0;
            FLAG_DETECT: flag_q <= 1'b1;
            FLAG_SOFT:   flag_q <= flag_wr_val;
            default:     flag_q <= flag_q;
        endcase
    end

    // Place the flag into the status word.
    always_comb begin
        status_word               = '0;
        status_word[MISMATCH_BIT] = flag_q;
    end
endmodule

// File: rtl/cfg_shadow_monitor.sv
// Module: cfg_shadow_monitor (top)
// Protected register bank with continuous twin comparison, a mismatch reset
// request and a sticky flag. Assumes rst_n and por_n are synchronous to clk.
module cfg_shadow_monitor
    import cfgmon_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1,
    localparam int FLAT_W  = NUM_REGS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                inj_en,
    input  logic [ADDR_W-1:0]   inj_addr,
    input  logic [BIT_W-1:0]    inj_bit,
    input  logic                flag_wr_en,
    input  logic                flag_wr_val,
    output logic [FLAT_W-1:0]   cfg_flat,
    output logic                mm_rst_req,
    output logic [STATUS_W-1:0] status_word
);
    logic [FLAT_W-1:0] twin_flat;
    logic              mismatch;

    cfgmon_bank #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
        .live_flat(cfg_flat), .shadow_flat(twin_flat)
    );

    cfgmon_compare #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_cmp (
        .live_flat(cfg_flat), .shadow_flat(twin_flat), .mismatch(mismatch)
    );

    cfgmon_flag u_flag (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .mismatch(mismatch),
        .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
        .req(mm_rst_req), .status_word(status_word)
    );
endmodule

// File: rtl/cfg_shadow_monitor_chk.sv
// Module: cfg_shadow_monitor_chk
// Assertion checker bound to the top. It observes ports and the internal
// mismatch level.
module cfg_shadow_monitor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        por_n,
    input logic        inj_en,
    input logic        flag_wr_en,
    input logic        mismatch,
    input logic        mm_rst_req,
    input logic [15:0] status_word
);
    // R5: the request lasts a single cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rst_req |=> !mm_rst_req);

    // R7: whenever a request is seen, the flag is already set.
    a_r7_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rst_req |-> status_word[9]);

    // R3: a disagreement can only appear after an injection.
    a_r3_no_false_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> $past(inj_en));

    // R5: a request follows a mismatch that was present in the prior cycle.
    a_r5_req_from_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rst_req |-> $past(mismatch));

    // R7: the flag holds without a power-on reset or a software write.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (status_word[9] && !flag_wr_en) |=> status_word[9]);

    // R8: a power-on reset clears the flag.
    a_r8_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !por_n |=> !status_word[9]);
endmodule

bind cfg_shadow_monitor cfg_shadow_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .inj_en(inj_en),
    .flag_wr_en(flag_wr_en), .mismatch(mismatch),
    .mm_rst_req(mm_rst_req), .status_word(status_word)
);

// File: tb/cfg_shadow_monitor_test.sv
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// outputs from the requirements and queues them. The monitor pops and compares.
module cfg_shadow_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        inj_en = 1'b0;
    logic [2:0]  inj_addr = '0;
    logic [2:0]  inj_bit = '0;
    logic        flag_wr_en = 1'b0;
    logic        flag_wr_val = 1'b0;
    logic [63:0] cfg_flat;
    logic        mm_rst_req;
    logic [15:0] status_word;

    always #2 clk = ~clk;

    cfg_shadow_monitor uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
        .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
        .cfg_flat(cfg_flat), .mm_rst_req(mm_rst_req), .status_word(status_word)
    );

    typedef struct {
        logic [63:0] cfg;
        logic        req;
        logic [15:0] status;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    logic [7:0] m_live [8];
    logic [7:0] m_twin [8];
    logic       m_prev = 1'b0;
    logic       m_req = 1'b0;
    logic       m_flag = 1'b0;

    // Drive one cycle of inputs and queue the outputs predicted after the edge.
    task automatic step(input logic r, input logic p, input logic we,
                        input logic [2:0] wa, input logic [7:0] wd,
                        input logic ie, input logic [2:0] ia, input logic [2:0] ib,
                        input logic fe, input logic fv, input string tag);
        logic mm;
        logic det;
        exp_t e;
        @(negedge clk);
        rst_n = r; por_n = p; wr_en = we; wr_addr = wa; wr_data = wd;
        inj_en = ie; inj_addr = ia; inj_bit = ib; flag_wr_en = fe; flag_wr_val = fv;
        mm = 1'b0;
        for (int i = 0; i < 8; i++) if (m_live[i] != m_twin[i]) mm = 1'b1;
        det = r && mm && !m_prev;
        if (!p) m_flag = 1'b0;
        else if (det) m_flag = 1'b1;
        else if (fe) m_flag = fv;
        if (!r) begin
            for (int i = 0; i < 8; i++) begin m_live[i] = '0; m_twin[i] = '0; end
            m_prev = 1'b0;
            m_req = 1'b0;
        end else begin
            m_req = det;
            m_prev = mm;
            if (we) begin m_live[wa] = wd; m_twin[wa] = wd; end
            if (ie) m_live[ia] = m_live[ia] ^ (8'h01 << ib);
        end
        for (int i = 0; i < 8; i++) e.cfg[i*8 +: 8] = m_live[i];
        e.req = m_req;
        e.status = 16'h0;
        e.status[9] = m_flag;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare the outputs just after each edge against the queue head.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (cfg_flat !== e.cfg || mm_rst_req !== e.req || status_word !== e.status) begin
                bad++;
                $display("FAIL %s: cfg=%h req=%b status=%h expected cfg=%h req=%b status=%h",
                         e.tag, cfg_flat, mm_rst_req, status_word, e.cfg, e.req, e.status);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_live[i] = '0; m_twin[i] = '0; end
        // R1: power-on plus device reset.
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        idle("R1 idle after reset");
        // R2/R3: write every slot with distinct data.
        for (int i = 0; i < 8; i++) step(1, 1, 1, 3'(i), 8'(8'h11 * (i + 1)), 0, 0, 0, 0, 0, "R2 R3 write");
        step(1, 1, 1, 3'd2, 8'h33, 0, 0, 0, 0, 0, "R3 repeated write");
        idle("R3 no request");
        // R4/R5/R6/R7: disturb slot 3 bit 5.
        step(1, 1, 0, 0, 0, 1, 3'd3, 3'd5, 0, 0, "R4 injection");
        idle("R5 R7 request and flag");
        idle("R5 single pulse");
        idle("R6 no repeat");
        idle("R6 no repeat");
        // R7/R1: device reset keeps the flag.
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 R1 flag survives rst_n");
        idle("R7 after reset");
        // R8: software writes.
        step(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R8 soft clear");
        step(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R8 soft set");
        step(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R8 soft clear");
        // R11/R6: corrupt slot 0, then rewrite it.
        step(1, 1, 1, 3'd0, 8'hA5, 0, 0, 0, 0, 0, "R2 write slot 0");
        step(1, 1, 0, 0, 0, 1, 3'd0, 3'd0, 0, 0, "R4 injection slot 0");
        step(1, 1, 1, 3'd0, 8'hA5, 0, 0, 0, 0, 0, "R11 rewrite restores");
        idle("R11 no further request");
        idle("R11 no further request");
        step(1, 1, 0, 0, 0, 1, 3'd0, 3'd7, 0, 0, "R6 new disturbance");
        idle("R6 new request");
        step(1, 1, 1, 3'd0, 8'hA5, 0, 0, 0, 1, 0, "R11 R8 rewrite and clear");
        idle("R11 settled");
        // R9: detection coincides with a software clear.
        step(1, 1, 0, 0, 0, 1, 3'd6, 3'd1, 0, 0, "R9 injection");
        step(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R9 set wins over clear");
        idle("R9 flag stays");
        step(1, 1, 1, 3'd6, 8'h77, 0, 0, 0, 1, 0, "R9 repair and clear");
        idle("R9 settled");
        // R10: write and injection on the same slot in the same cycle.
        step(1, 1, 1, 3'd5, 8'h3C, 1, 3'd5, 3'd2, 0, 0, "R10 write plus flip");
        idle("R10 request");
        idle("R10 single pulse");
        // R1/R8: full power-on reset clears everything.
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 R8 power-on reset");
        idle("R1 clean after power-on");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule